// File: doc/BRIEF.md
# Two-Stage Fetch Sequencer

This block is the front end of a small 32-bit core that runs in two stages: a fetch stage and one combined stage that decodes, executes and writes back. It owns the program counter, drives the word address of an instruction memory whose read data returns in the same cycle, and captures the fetched word in an instruction register. The execute stage reads its instruction from that register. Alongside it, the block carries the PC+4 of that instruction, so that branch targets and link values are formed from the correct PC.

Software sees no branch delay slot. When the execute stage reports a taken conditional branch, or any jump, together with a target byte address, the word fetched in that same cycle is on the wrong path. The block loads an all-zero word, which the core treats as a nop, into the instruction register in its place, and the PC takes the target on that clock edge. A branch that is not taken changes nothing. After reset the instruction register holds a nop, so the first execute cycle does nothing while the word at address zero is being fetched.

Top module: `fetch_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `imem_addr` = 0, `ex_instr` = 0 and `ex_pc_plus4` = 0.
- R2: `imem_addr` equals bits [25:2] of the byte PC. The two low PC bits and PC bits 31:26 do not reach the address.
- R3: With `br_taken` and `jump` both low, the PC grows by 4 at each edge. The word read during a cycle appears on `ex_instr` after the next edge, and `ex_pc_plus4` shows that word's PC plus 4.
- R4: `br_taken` high at an edge loads `redirect_pc` into the PC and puts 0x00000000 on `ex_instr` for the next cycle instead of the fetched word.
- R5: `jump` high at an edge has the same effect as R4, a load of `redirect_pc` and a nop in place of the fetched word.
- R6: With `br_taken` and `jump` both low, `redirect_pc` has no effect: the fetched word is kept and the PC steps by 4.
- R7: `ex_pc_plus4` carries all 32 PC bits plus 4, including upper bits that the memory address drops.
- R8: A branch whose target equals its own PC (offset 0xFFFF, target = PC+4 - 4) repeats indefinitely, with exactly one nop between consecutive executions of the branch.
- R9: After reset is released, the first execute cycle holds a nop, and the word at address 0 reaches `ex_instr` one edge later with `ex_pc_plus4` = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_rdata | input | 32 | Instruction memory read data for `imem_addr` |
| br_taken | input | 1 | Execute stage: conditional branch is taken |
| jump | input | 1 | Execute stage: a jump of any kind is executing |
| redirect_pc | input | 32 | Target byte address for a taken branch or a jump |
| imem_addr | output | 24 | Instruction memory word address |
| ex_instr | output | 32 | Instruction presented to the execute stage |
| ex_pc_plus4 | output | 32 | PC+4 of the instruction on `ex_instr` |

## Verification
The bench drives redirects whose targets set PC bits above bit 25 and reach the top of the 24-bit word space. A design that sliced the wrong PC bits would show the wrong `imem_addr`, or lose the upper bits of `ex_pc_plus4`. A not-taken cycle carries a nonzero `redirect_pc`, so a design that killed or redirected without a taken condition would show a nop or a jump in the address. A self-targeting branch is run for several loops: a design that killed the wrong slot, or did not kill at all, would let the word after the branch execute or would break the one-nop rhythm. A reset in the middle of a run checks the return to address zero and the nop on the first execute cycle.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
   // Word forced into the execute slot when a fetch is squashed
   localparam logic [31:0] NOP_WORD = 32'h0000_0000;
   // Byte offset of an instruction word
   localparam int unsigned INSTR_BYTES = 4;
   localparam int unsigned BYTE_SHIFT  = $clog2(INSTR_BYTES);
endpackage

// File: rtl/fseq_pc_unit.sv
module fseq_pc_unit
   import fetch_seq_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned IMEM_AW = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              redirect,
   input  logic [XLEN-1:0]   target,
   output logic [XLEN-1:0]   pc,
   output logic [XLEN-1:0]   pc_seq,
   output logic [IMEM_AW-1:0] fetch_addr
);
   localparam int unsigned ADDR_LO = BYTE_SHIFT;
   localparam int unsigned ADDR_HI = BYTE_SHIFT + IMEM_AW - 1;
   localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

   initial begin
      assert (XLEN > BYTE_SHIFT) else $fatal(1, "XLEN too small");
      assert (IMEM_AW > 0) else $fatal(1, "IMEM_AW must be positive");
   end

   logic [XLEN-1:0] pc_q;

   assign pc_seq = pc_q + STEP;

   always_ff @(posedge clk) begin
      if (rst)           pc_q <= '0;
      else if (redirect) pc_q <= target;
      else               pc_q <= pc_seq;
   end

   assign pc = pc_q;

   generate
      if (ADDR_HI < XLEN) begin : g_slice
         assign fetch_addr = pc_q[ADDR_HI:ADDR_LO];
      end else begin : g_pad
         assign fetch_addr = IMEM_AW'(pc_q[XLEN-1:ADDR_LO]);
      end
   endgenerate

   // R4/R5: a redirect loads the target on the next edge
   a_r4_redirect_load: assert property (@(posedge clk) disable iff (rst)
      redirect |=> pc_q == $past(target));

   // R3/R6: without a redirect the PC steps by one word
   a_r3_seq_step: assert property (@(posedge clk) disable iff (rst)
      !redirect |=> pc_q == $past(pc_q) + STEP);
endmodule

// File: rtl/fseq_instr_latch.sv
module fseq_instr_latch
   import fetch_seq_pkg::*;
#(
   parameter int unsigned XLEN = 32,
   parameter int unsigned ILEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            squash,
   input  logic [ILEN-1:0] fetch_word,
   input  logic [XLEN-1:0] fetch_pc4,
   output logic [ILEN-1:0] ir,
   output logic [XLEN-1:0] ir_pc4
);
   localparam logic [ILEN-1:0] NOP = ILEN'(NOP_WORD);

   initial begin
      assert (ILEN >= 1) else $fatal(1, "ILEN must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ir     <= NOP;
         ir_pc4 <= '0;
      end else begin
         ir     <= squash ? NOP : fetch_word;
         ir_pc4 <= fetch_pc4;
      end
   end

   // R4/R5: a squashed fetch never reaches execute
   a_r4_kill_nop: assert property (@(posedge clk) disable iff (rst)
      squash |=> ir == NOP);

   // R6: a fetch that is not squashed is passed on unchanged
   a_r6_keep_word: assert property (@(posedge clk) disable iff (rst)
      !squash |=> ir == $past(fetch_word));

   // R7: the PC+4 tag travels with its word
   a_r7_tag_follows: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ir_pc4 == $past(fetch_pc4));
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
   import fetch_seq_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned ILEN    = 32,
   parameter int unsigned IMEM_AW = 24
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ILEN-1:0]    imem_rdata,
   input  logic               br_taken,
   input  logic               jump,
   input  logic [XLEN-1:0]    redirect_pc,
   output logic [IMEM_AW-1:0] imem_addr,
   output logic [ILEN-1:0]    ex_instr,
   output logic [XLEN-1:0]    ex_pc_plus4
);
   logic            kill;
   logic [XLEN-1:0] pc;
   logic [XLEN-1:0] pc_seq;

   // Any jump, or only a branch that is taken, steers fetch away
   assign kill = br_taken | jump;

   fseq_pc_unit #(.XLEN(XLEN), .IMEM_AW(IMEM_AW)) u_pc (
      .clk        (clk),
      .rst        (rst),
      .redirect   (kill),
      .target     (redirect_pc),
      .pc         (pc),
      .pc_seq     (pc_seq),
      .fetch_addr (imem_addr)
   );

   fseq_instr_latch #(.XLEN(XLEN), .ILEN(ILEN)) u_ir (
      .clk        (clk),
      .rst        (rst),
      .squash     (kill),
      .fetch_word (imem_rdata),
      .fetch_pc4  (pc_seq),
      .ir         (ex_instr),
      .ir_pc4     (ex_pc_plus4)
   );

   // R5: a jump always kills, whatever the branch input says
   a_r5_jump_kills: assert property (@(posedge clk) disable iff (rst)
      jump |=> ex_instr == ILEN'(NOP_WORD));

   // R3: the execute tag is one word past the PC that was fetching
   a_r3_tag_matches_pc: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ex_pc_plus4 == $past(pc) + XLEN'(INSTR_BYTES));
endmodule

// File: tb/fetch_sequencer_tb.sv
module fetch_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_rdata;
   logic        br_taken = 1'b0;
   logic        jump = 1'b0;
   logic [31:0] redirect_pc = '0;
   logic [23:0] imem_addr;
   logic [31:0] ex_instr;
   logic [31:0] ex_pc_plus4;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   // Memory model: each word names its own address
   assign imem_rdata = {8'h3C, imem_addr};

   fetch_sequencer u_dut (
      .clk(clk), .rst(rst), .imem_rdata(imem_rdata),
      .br_taken(br_taken), .jump(jump), .redirect_pc(redirect_pc),
      .imem_addr(imem_addr), .ex_instr(ex_instr), .ex_pc_plus4(ex_pc_plus4)
   );

   // {br, jmp, target, exp addr, exp instr, exp pc+4}
   localparam int NV = 10;
   localparam logic [121:0] VEC [NV] = '{
      {1'b0, 1'b0, 32'h0000_0000, 24'h000001, 32'h3C00_0000, 32'h0000_0004},
      {1'b0, 1'b0, 32'h0000_0000, 24'h000002, 32'h3C00_0001, 32'h0000_0008},
      {1'b1, 1'b0, 32'h0000_0040, 24'h000010, 32'h0000_0000, 32'h0000_000C},
      {1'b0, 1'b0, 32'h0000_0000, 24'h000011, 32'h3C00_0010, 32'h0000_0044},
      {1'b0, 1'b0, 32'h0000_0100, 24'h000012, 32'h3C00_0011, 32'h0000_0048},
      {1'b0, 1'b1, 32'hFC00_0200, 24'h000080, 32'h0000_0000, 32'h0000_004C},
      {1'b0, 1'b0, 32'h0000_0000, 24'h000081, 32'h3C00_0080, 32'hFC00_0204},
      {1'b0, 1'b1, 32'h03FF_FFFC, 24'hFFFFFF, 32'h0000_0000, 32'hFC00_0208},
      {1'b0, 1'b0, 32'h0000_0000, 24'h000000, 32'h3CFF_FFFF, 32'h0400_0000},
      {1'b0, 1'b0, 32'h0000_0000, 24'h000001, 32'h3C00_0000, 32'h0400_0004}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive at the falling edge, sample at the next falling edge
   task automatic step(input logic b, input logic j, input logic [31:0] t);
      br_taken = b; jump = j; redirect_pc = t;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] self_tgt;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 addr",  {8'h0, imem_addr}, 32'h0);
      check("R1 instr", ex_instr, 32'h0);
      check("R1 pc4",   ex_pc_plus4, 32'h0);
      rst = 1'b0;

      // R2..R7 vector walk
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][121], VEC[i][120], VEC[i][119:88]);
         check($sformatf("R2 addr v%0d", i), {8'h0, imem_addr}, {8'h0, VEC[i][87:64]});
         check($sformatf("R3/R4/R5/R6 instr v%0d", i), ex_instr, VEC[i][63:32]);
         check($sformatf("R7 pc4 v%0d", i), ex_pc_plus4, VEC[i][31:0]);
      end

      // R8: self-looping branch at byte 0x200
      step(1'b0, 1'b1, 32'h0000_0200);
      step(1'b0, 1'b0, 32'h0);
      for (int k = 0; k < 4; k++) begin
         check("R8 branch in ex", ex_instr, 32'h3C00_0080);
         check("R8 branch pc4", ex_pc_plus4, 32'h0000_0204);
         self_tgt = ex_pc_plus4 + {{14{1'b1}}, 16'hFFFF, 2'b00};
         step(1'b1, 1'b0, self_tgt);
         check("R8 killed slot", ex_instr, 32'h0);
         check("R8 refetch addr", {8'h0, imem_addr}, 32'h0000_0080);
         step(1'b0, 1'b0, 32'h0);
      end

      // R1/R9: reset mid-run, then first execute cycles
      rst = 1'b1;
      step(1'b0, 1'b0, 32'h0);
      check("R1 mid addr",  {8'h0, imem_addr}, 32'h0);
      check("R1 mid instr", ex_instr, 32'h0);
      check("R1 mid pc4",   ex_pc_plus4, 32'h0);
      rst = 1'b0;
      step(1'b0, 1'b0, 32'h0);
      check("R9 first word", ex_instr, 32'h3C00_0000);
      check("R9 first pc4",  ex_pc_plus4, 32'h0000_0004);
      check("R9 next addr",  {8'h0, imem_addr}, 32'h0000_0001);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule